// File: doc/BRIEF.md
# Edge-Selectable Digital PWM with Output-Voltage Sample Trigger

This block is the timing core of a voltage-mode digital controller for a constant-frequency switching converter. A free-running ramp counter sets the switching period. Each period, a gate signal is produced from a duty command in one of two modulation modes. In trailing-edge mode the gate switches on at ramp start and the turn-off edge is modulated. In leading-edge mode the gate is off at ramp start and the turn-on edge is modulated.

Once per period the block also pulses a one-cycle strobe that tells an external converter when to sample the output voltage. The strobe is placed a programmable number of cycles ahead of the next ramp start, which models conversion and computation latency. The duty command is clamped so that the sample lands while the switch is off in trailing-edge mode and while it is on in leading-edge mode. The clamp also keeps the loop delay from the sample to the modulated edge below one period.

All three inputs (duty, mode, delay) are captured only at the period boundary, so a period is always produced from a single consistent setting. Outputs are registered. Phase 0 of a period is the cycle in which `start_o` is high.

Top module: `dpwm_edge_sel`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first `start_o` pulse, `gate_o`, `sample_o` and `start_o` are all low.
- R2: `start_o` is high for exactly one cycle every PERIOD cycles, and it marks phase 0 of each period.
- R3: Exactly one `sample_o` pulse occurs per period, at phase PERIOD-1-d. Here d is the captured `delay_i` after the clamp of R9.
- R4: In trailing-edge mode (`mode_i` = 0), with a captured duty c in 1..PERIOD-1, `gate_o` is high in phases 0..e-1 and low elsewhere, where e = min(c, PERIOD-1-d).
- R5: In leading-edge mode (`mode_i` = 1), with a captured duty c in 1..PERIOD-1, `gate_o` is high in phases PERIOD-e..PERIOD-1 and low elsewhere, where e = max(c, d+1).
- R6: In either mode, a captured duty of 0 holds `gate_o` low for the whole period, and a captured duty of PERIOD or more holds it high for the whole period.
- R7: `duty_i`, `mode_i` and `delay_i` are captured only at the clock edge that starts a period. Changes at any other time do not alter the waveform of the period in progress.
- R8: For a duty in 1..PERIOD-1, `gate_o` is low in the `sample_o` cycle in trailing-edge mode and high in it in leading-edge mode.
- R9: A `delay_i` value above PERIOD-2 is treated as PERIOD-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | CW | Duty command in clock counts; PERIOD or more means full on |
| mode_i | input | 1 | 0 = trailing-edge modulation, 1 = leading-edge modulation |
| delay_i | input | CW | Cycles from the sample strobe to the next ramp start |
| gate_o | output | 1 | Switch gate drive |
| sample_o | output | 1 | One-cycle output-voltage sample strobe |
| start_o | output | 1 | One-cycle ramp/period start strobe |

## Verification
On every cycle, the assertions check the following:
- the period spacing of `start_o`;
- that there is exactly one sample strobe per period;
- that the gate level during the sample strobe matches the mode;
- that trailing-edge gates rise, and leading-edge gates fall, only at period start;
- that the captured setting stays frozen between boundaries;
- that the outputs stay quiet before the first period.

The exact edge positions under each clamp, the position of the sample strobe for a given delay, and the full-on and full-off cases can only be shown by the bench's scenarios. The same holds for the proof that mid-period input changes leave the running period untouched. In those scenarios a reference waveform for each period is compared with the observed one.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    typedef enum logic {
        EDGE_TRAIL = 1'b0,
        EDGE_LEAD  = 1'b1
    } edge_mode_e;

endpackage

// File: rtl/dpwm_ramp_ctr.sv
module dpwm_ramp_ctr #(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = (st_q.cnt == LAST);
endmodule

// File: rtl/dpwm_cfg_latch.sv
module dpwm_cfg_latch
    import dpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] duty_i,
    input  logic          mode_i,
    input  logic [CW-1:0] delay_i,
    output edge_mode_e    mode_o,
    output logic          force_on_o,
    output logic          force_off_o,
    output logic [CW-1:0] thr_o,
    output logic [CW-1:0] smp_o
);
    localparam logic [CW-1:0] P_V  = CW'(PERIOD);
    localparam logic [CW-1:0] P_M1 = CW'(PERIOD - 1);
    localparam logic [CW-1:0] P_M2 = CW'(PERIOD - 2);

    typedef struct packed {
        edge_mode_e    mode;
        logic          force_on;
        logic          force_off;
        logic [CW-1:0] thr;
        logic [CW-1:0] smp;
    } cfg_state_t;

    cfg_state_t    st_d, st_q;
    logic [CW-1:0] dly_c;
    logic [CW-1:0] te_lim;
    logic [CW-1:0] le_min;
    logic [CW-1:0] eff;

    always_comb begin
        st_d   = st_q;
        dly_c  = (delay_i > P_M2) ? P_M2 : delay_i;
        te_lim = P_M1 - dly_c;
        le_min = dly_c + 1'b1;
        eff    = '0;
        if (load_i) begin
            st_d.mode      = edge_mode_e'(mode_i);
            st_d.force_off = (duty_i == '0);
            st_d.force_on  = (duty_i >= P_V);
            st_d.smp       = te_lim;
            if (mode_i == EDGE_LEAD) begin
                eff      = (duty_i > le_min) ? duty_i : le_min;
                st_d.thr = P_V - eff;
            end else begin
                eff      = (duty_i < te_lim) ? duty_i : te_lim;
                st_d.thr = eff;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode      <= EDGE_TRAIL;
            st_q.force_on  <= 1'b0;
            st_q.force_off <= 1'b1;
            st_q.thr       <= '0;
            st_q.smp       <= P_M1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o      = st_q.mode;
    assign force_on_o  = st_q.force_on;
    assign force_off_o = st_q.force_off;
    assign thr_o       = st_q.thr;
    assign smp_o       = st_q.smp;
endmodule

// File: rtl/dpwm_out_stage.sv
module dpwm_out_stage
    import dpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] cnt_i,
    input  edge_mode_e    mode_i,
    input  logic          force_on_i,
    input  logic          force_off_i,
    input  logic [CW-1:0] thr_i,
    input  logic [CW-1:0] smp_i,
    output logic          gate_o,
    output logic          sample_o,
    output logic          start_o,
    output edge_mode_e    mode_o,
    output logic          forced_o
);
    typedef struct packed {
        logic       armed;
        logic       gate;
        logic       sample;
        logic       start;
        edge_mode_e mode;
        logic       forced;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       level;

    always_comb begin
        st_d       = st_q;
        st_d.armed = st_q.armed | (cnt_i == '0);
        if (force_off_i) begin
            level = 1'b0;
        end else if (force_on_i) begin
            level = 1'b1;
        end else if (mode_i == EDGE_LEAD) begin
            level = (cnt_i >= thr_i);
        end else begin
            level = (cnt_i < thr_i);
        end
        st_d.gate   = st_d.armed & level;
        st_d.start  = st_d.armed & (cnt_i == '0);
        st_d.sample = st_d.armed & (cnt_i == smp_i);
        st_d.mode   = mode_i;
        st_d.forced = force_on_i | force_off_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.armed  <= 1'b0;
            st_q.gate   <= 1'b0;
            st_q.sample <= 1'b0;
            st_q.start  <= 1'b0;
            st_q.mode   <= EDGE_TRAIL;
            st_q.forced <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o   = st_q.gate;
    assign sample_o = st_q.sample;
    assign start_o  = st_q.start;
    assign mode_o   = st_q.mode;
    assign forced_o = st_q.forced;
endmodule

// File: rtl/dpwm_edge_sel.sv
module dpwm_edge_sel
    import dpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] duty_i,
    input  logic          mode_i,
    input  logic [CW-1:0] delay_i,
    output logic          gate_o,
    output logic          sample_o,
    output logic          start_o
);
    logic [CW-1:0] cnt_q;
    logic          wrap;
    edge_mode_e    cfg_mode;
    logic          cfg_force_on;
    logic          cfg_force_off;
    logic [CW-1:0] cfg_thr;
    logic [CW-1:0] cfg_smp;
    edge_mode_e    out_mode;
    logic          out_forced;

    dpwm_ramp_ctr #(.PERIOD(PERIOD), .CW(CW)) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt_q),
        .wrap_o (wrap)
    );

    dpwm_cfg_latch #(.PERIOD(PERIOD), .CW(CW)) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (wrap),
        .duty_i      (duty_i),
        .mode_i      (mode_i),
        .delay_i     (delay_i),
        .mode_o      (cfg_mode),
        .force_on_o  (cfg_force_on),
        .force_off_o (cfg_force_off),
        .thr_o       (cfg_thr),
        .smp_o       (cfg_smp)
    );

    dpwm_out_stage #(.PERIOD(PERIOD), .CW(CW)) u_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_i       (cnt_q),
        .mode_i      (cfg_mode),
        .force_on_i  (cfg_force_on),
        .force_off_i (cfg_force_off),
        .thr_i       (cfg_thr),
        .smp_i       (cfg_smp),
        .gate_o      (gate_o),
        .sample_o    (sample_o),
        .start_o     (start_o),
        .mode_o      (out_mode),
        .forced_o    (out_forced)
    );
endmodule

// File: rtl/dpwm_sva.sv
module dpwm_sva
    import dpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          gate_o,
    input logic          sample_o,
    input logic          start_o,
    input logic [CW-1:0] cnt_q,
    input edge_mode_e    cfg_mode,
    input logic          cfg_force_on,
    input logic          cfg_force_off,
    input logic [CW-1:0] cfg_thr,
    input logic [CW-1:0] cfg_smp,
    input edge_mode_e    out_mode,
    input logic          out_forced
);
    logic          seen_q;
    logic          smp_seen_q;
    logic [CW-1:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q     <= 1'b0;
            smp_seen_q <= 1'b0;
            gap_q      <= '0;
        end else begin
            seen_q     <= seen_q | start_o;
            smp_seen_q <= start_o ? sample_o : (smp_seen_q | sample_o);
            if (start_o) begin
                gap_q <= '0;
            end else if (gap_q != CW'(PERIOD)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    p_quiet_before_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!seen_q && !start_o) |-> (!gate_o && !sample_o));

    p_start_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o && seen_q) |-> (gap_q == CW'(PERIOD - 1)));

    p_no_early_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && gap_q < CW'(PERIOD - 1)) |-> !start_o);

    p_single_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o && !start_o) |-> !smp_seen_q);

    p_sample_each_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o && seen_q) |-> smp_seen_q);

    p_trail_rise_at_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(gate_o) && out_mode == EDGE_TRAIL) |-> start_o);

    p_lead_fall_at_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(gate_o) && out_mode == EDGE_LEAD) |-> start_o);

    p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0) |-> ($stable(cfg_mode) && $stable(cfg_force_on) &&
                           $stable(cfg_force_off) && $stable(cfg_thr) && $stable(cfg_smp)));

    p_trail_sample_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o && !out_forced && out_mode == EDGE_TRAIL) |-> !gate_o);

    p_lead_sample_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o && !out_forced && out_mode == EDGE_LEAD) |-> gate_o);
endmodule

bind dpwm_edge_sel dpwm_sva #(.PERIOD(PERIOD), .CW(CW)) u_sva (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .gate_o        (gate_o),
    .sample_o      (sample_o),
    .start_o       (start_o),
    .cnt_q         (cnt_q),
    .cfg_mode      (cfg_mode),
    .cfg_force_on  (cfg_force_on),
    .cfg_force_off (cfg_force_off),
    .cfg_thr       (cfg_thr),
    .cfg_smp       (cfg_smp),
    .out_mode      (out_mode),
    .out_forced    (out_forced)
);

// File: tb/dpwm_edge_sel_tb_top.sv
`timescale 1ns/1ps
module dpwm_edge_sel_tb_top;
    localparam int P  = 20;
    localparam int CW = $clog2(P + 1);

    typedef struct {
        int cmd;
        bit mode;
        int dly;
    } tb_cfg_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] duty = '0;
    logic          mode = 1'b0;
    logic [CW-1:0] dly = '0;
    logic          gate, sample, start;

    int      checks = 0;
    int      errors = 0;
    int      cycles = 0;
    bit      done = 0;
    tb_cfg_t exp_q[$];

    always #2.5 clk = ~clk;

    dpwm_edge_sel #(.PERIOD(P), .CW(CW)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .duty_i   (duty),
        .mode_i   (mode),
        .delay_i  (dly),
        .gate_o   (gate),
        .sample_o (sample),
        .start_o  (start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp_dly(input int d);
        return (d > P - 2) ? P - 2 : d;
    endfunction

    function automatic bit ref_gate(input tb_cfg_t c, input int k);
        int d, e;
        d = clamp_dly(c.dly);
        if (c.cmd == 0) return 1'b0;
        if (c.cmd >= P) return 1'b1;
        if (c.mode) begin
            e = (c.cmd > d + 1) ? c.cmd : d + 1;
            return k >= P - e;
        end
        e = (c.cmd < P - 1 - d) ? c.cmd : P - 1 - d;
        return k < e;
    endfunction

    task automatic drive(input tb_cfg_t c);
        duty = CW'(c.cmd);
        mode = c.mode;
        dly  = CW'(c.dly);
    endtask

    // Monitor: compares each completed period against its queued reference.
    initial begin
        tb_cfg_t cur;
        bit      have = 0;
        int      phase = 0, mism = 0, nsmp = 0, smp_at = -1, gate_at_smp = 0;
        string   tag;
        forever begin
            @(negedge clk);
            if (start) begin
                if (have) begin
                    check(phase == P, "R2", phase, P);
                    tag = (cur.cmd == 0 || cur.cmd >= P) ? "R6" : (cur.mode ? "R5" : "R4");
                    check(mism == 0, tag, mism, 0);
                    check(nsmp == 1, "R3", nsmp, 1);
                    check(smp_at == P - 1 - clamp_dly(cur.dly),
                          (cur.dly > P - 2) ? "R9" : "R3", smp_at, P - 1 - clamp_dly(cur.dly));
                    if (cur.cmd > 0 && cur.cmd < P)
                        check(gate_at_smp == int'(cur.mode), "R8", gate_at_smp, int'(cur.mode));
                end
                have = (exp_q.size() > 0);
                if (have) cur = exp_q.pop_front();
                phase = 0; mism = 0; nsmp = 0; smp_at = -1; gate_at_smp = 0;
            end
            if (have) begin
                if (gate !== ref_gate(cur, phase)) mism++;
                if (sample) begin
                    nsmp++;
                    smp_at = phase;
                    gate_at_smp = int'(gate);
                end
            end
            phase++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            check(1'b0, "watchdog", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        tb_cfg_t list[12];
        tb_cfg_t junk;
        list[0]  = '{cmd: 10, mode: 0, dly: 0};
        list[1]  = '{cmd: 8,  mode: 0, dly: 2};
        list[2]  = '{cmd: 18, mode: 0, dly: 4};
        list[3]  = '{cmd: 8,  mode: 1, dly: 2};
        list[4]  = '{cmd: 2,  mode: 1, dly: 5};
        list[5]  = '{cmd: 0,  mode: 0, dly: 3};
        list[6]  = '{cmd: 20, mode: 1, dly: 3};
        list[7]  = '{cmd: 31, mode: 0, dly: 1};
        list[8]  = '{cmd: 0,  mode: 1, dly: 6};
        list[9]  = '{cmd: 5,  mode: 0, dly: 25};
        list[10] = '{cmd: 3,  mode: 1, dly: 30};
        list[11] = '{cmd: 1,  mode: 0, dly: 0};
        junk = '{cmd: 17, mode: 1, dly: 9};

        drive(list[0]);
        exp_q.push_back(list[0]);
        repeat (4) begin
            @(negedge clk);
            check(!gate && !sample && !start, "R1", {gate, sample, start}, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(!gate && !sample && !start, "R1", {gate, sample, start}, 0);

        for (int i = 1; i < 12; i++) begin
            @(negedge clk);
            while (!start) @(negedge clk);
            #1;
            repeat (3) @(negedge clk);
            drive(junk);          // R7: mid-period change must not disturb this period
            repeat (3) @(negedge clk);
            drive(list[i]);
            exp_q.push_back(list[i]);
        end
        for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            while (!start) @(negedge clk);
        end
        @(negedge clk);
        check(exp_q.size() == 0, "R7", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule